// File: doc/BRIEF.md
# Reservation Station Bank with Tag Wakeup and Oldest-First Select

This block holds a small pool of waiting operations for a single fixed-latency execution unit. Dispatch writes an operation into a free slot. Each source operand arrives in one of two ways: as a finished value with its ready flag set, or as the tag of the slot that will produce it. Waiting slots compare their tags against two sources every cycle: an external result bus that carries a tag and data together, and the results of their own unit. A matching value is captured on the spot.

Once a slot has both operands, it asks for the unit. One slot per cycle wins, and the oldest allocation always has priority. The winner gives up its slot in the same cycle. A slot that loses keeps asking until it is picked. A parameter selects the wakeup scheme. In the early variant, the unit announces a result tag one cycle before the data appears. A dependant can then be picked in the very cycle the data shows up, and that data is steered straight into the unit. In the plain variant, a dependant waits until the result has been written into its slot.

Top module: `rs_bank`

## Requirements
- R1: After reset every slot is empty: `disp_full`, `issue_valid`, `res_valid` and `wake_valid` are low, and `disp_tag` equals `BASE_TAG`.
- R2: Dispatch fills the lowest-numbered free slot. Slot n carries tag `BASE_TAG`+n, and `disp_tag` shows this tag before the clock edge that writes the slot. `disp_full` is high exactly when all slots are occupied, and a dispatch made while it is high changes nothing.
- R3: A waiting operand whose tag equals the tag on the external bus or on `res_tag` takes that data and becomes ready. This also applies in the dispatch cycle itself, so such a slot can be picked in the next cycle.
- R4: A slot asks for the unit only when both of its operands are ready. At most one slot is picked per cycle, and `issue_tag` names the picked slot.
- R5: Among the slots asking in a cycle, the one allocated earliest wins, whatever its slot number. If no age order exists between two slots, the lower index wins.
- R6: A slot that loses stays occupied and is picked in a later cycle without being dispatched again. A picked slot becomes free for dispatch in the next cycle.
- R7: A result appears `LAT` cycles after its pick, carrying the tag of the picked slot. The value depends on the op code: 0 gives vj+vk, 1 gives vj−vk, 2 gives the low `DW` bits of vj×vk, 3 gives vj xor vk.
- R8: With `EARLY_WAKE`=0, `wake_*` mirrors `res_*`. An operation that depends on its own unit is picked `LAT`+1 cycles after its producer.
- R9: With `EARLY_WAKE`=1 and `LAT`≥2, `wake_tag` appears `LAT`−1 cycles after the pick. A dependant is picked exactly `LAT` cycles after its producer and uses the producer's result as its operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 2 | Operation code (see R7) |
| disp_vj | input | DW | First operand value, used when disp_rj is high |
| disp_rj | input | 1 | First operand already available |
| disp_qj | input | TW | Producer tag of the first operand when not available |
| disp_vk | input | DW | Second operand value |
| disp_rk | input | 1 | Second operand already available |
| disp_qk | input | TW | Producer tag of the second operand |
| disp_full | output | 1 | No free slot; dispatch is ignored |
| disp_tag | output | TW | Tag that the next dispatch receives |
| cdb_valid | input | 1 | External result bus valid |
| cdb_tag | input | TW | External result bus tag |
| cdb_data | input | DW | External result bus data |
| issue_valid | output | 1 | A slot is picked this cycle |
| issue_tag | output | TW | Tag of the picked slot |
| res_valid | output | 1 | Unit result valid |
| res_tag | output | TW | Unit result tag |
| res_data | output | DW | Unit result value |
| wake_valid | output | 1 | Wakeup tag broadcast valid |
| wake_tag | output | TW | Wakeup tag |

## Verification
The assertions assume that no two in-flight producers share a tag. They also assume that the external bus never carries a tag owned by a slot of this bank. The stimulus keeps to this by placing external producer tags at 20 and above, which is outside the bank's range of 8 to 11. The assertions further assume that dispatch follows the full flag. The bench makes one deliberate dispatch while full, and only to confirm that it is dropped. Each external tag is broadcast once and only after its waiters are in place, except in the single case that tests capture in the dispatch cycle.

// File: rtl/rs_bank_pkg.sv
package rs_bank_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int NUM_ENT = 4,
    localparam int IW = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0] busy,
    output logic [NUM_ENT-1:0] pick_oh,
    output logic [IW-1:0]      pick_idx,
    output logic               all_busy
);

    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
                pick_idx   = IW'(i);
            end
        end
        all_busy = &busy;
    end

endmodule

// File: rtl/rs_age_sel.sv
module rs_age_sel #(
    parameter int NUM_ENT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] alloc_oh,
    input  logic [NUM_ENT-1:0] busy,
    input  logic [NUM_ENT-1:0] req,
    output logic [NUM_ENT-1:0] gnt_oh
);

    // older_q[i][j] set: slot j was allocated before slot i
    logic [NUM_ENT-1:0][NUM_ENT-1:0] older_q, older_d;

    always_comb begin
        older_d = older_q;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (alloc_oh[i]) begin
                for (int j = 0; j < NUM_ENT; j++) begin
                    older_d[j][i] = 1'b0;
                end
            end
        end
        for (int i = 0; i < NUM_ENT; i++) begin
            if (alloc_oh[i]) begin
                older_d[i]    = busy;
                older_d[i][i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    always_comb begin
        logic blk;
        gnt_oh = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            blk = 1'b0;
            for (int j = 0; j < NUM_ENT; j++) begin
                if (j != i && req[j] &&
                    (older_q[i][j] || (!older_q[j][i] && j < i))) begin
                    blk = 1'b1;
                end
            end
            gnt_oh[i] = req[i] && !blk;
        end
    end

endmodule

// File: rtl/rs_fu_pipe.sv
module rs_fu_pipe
    import rs_bank_pkg::*;
#(
    parameter int DW         = 16,
    parameter int TW         = 5,
    parameter int LAT        = 2,
    parameter bit EARLY_WAKE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [TW-1:0] iss_tag,
    input  alu_op_e       iss_op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic          res_valid,
    output logic [TW-1:0] res_tag,
    output logic [DW-1:0] res_data,
    output logic          wake_valid,
    output logic [TW-1:0] wake_tag
);

    logic [DW-1:0]          calc;
    logic [LAT-1:0]         stg_v;
    logic [LAT-1:0][TW-1:0] stg_t;
    logic [LAT-1:0][DW-1:0] stg_d;

    always_comb begin
        case (iss_op)
            OP_ADD:  calc = opa + opb;
            OP_SUB:  calc = opa - opb;
            OP_MUL:  calc = opa * opb;
            OP_XOR:  calc = opa ^ opb;
            default: calc = '0;
        endcase
    end

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                    stg_t[s] <= '0;
                    stg_d[s] <= '0;
                end else begin
                    stg_v[s] <= iss_valid;
                    stg_t[s] <= iss_tag;
                    stg_d[s] <= calc;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                    stg_t[s] <= '0;
                    stg_d[s] <= '0;
                end else begin
                    stg_v[s] <= stg_v[s-1];
                    stg_t[s] <= stg_t[s-1];
                    stg_d[s] <= stg_d[s-1];
                end
            end
        end
    end

    assign res_valid = stg_v[LAT-1];
    assign res_tag   = stg_t[LAT-1];
    assign res_data  = stg_d[LAT-1];

    if (EARLY_WAKE && LAT >= 2) begin : g_wake_early
        assign wake_valid = stg_v[LAT-2];
        assign wake_tag   = stg_t[LAT-2];
    end else if (EARLY_WAKE) begin : g_wake_issue
        assign wake_valid = iss_valid;
        assign wake_tag   = iss_tag;
    end else begin : g_wake_late
        assign wake_valid = res_valid;
        assign wake_tag   = res_tag;
    end

endmodule

// File: rtl/rs_bank.sv
module rs_bank
    import rs_bank_pkg::*;
#(
    parameter int NUM_ENT    = 4,
    parameter int DW         = 16,
    parameter int TW         = 5,
    parameter int LAT        = 2,
    parameter int BASE_TAG   = 8,
    parameter bit EARLY_WAKE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_valid,
    input  logic [1:0]    disp_op,
    input  logic [DW-1:0] disp_vj,
    input  logic          disp_rj,
    input  logic [TW-1:0] disp_qj,
    input  logic [DW-1:0] disp_vk,
    input  logic          disp_rk,
    input  logic [TW-1:0] disp_qk,
    output logic          disp_full,
    output logic [TW-1:0] disp_tag,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_data,
    output logic          issue_valid,
    output logic [TW-1:0] issue_tag,
    output logic          res_valid,
    output logic [TW-1:0] res_tag,
    output logic [DW-1:0] res_data,
    output logic          wake_valid,
    output logic [TW-1:0] wake_tag
);

    localparam int IW = $clog2(NUM_ENT);

    typedef struct packed {
        logic          rdy;
        logic          pend;   // woken by tag, data lands next cycle
        logic [TW-1:0] q;
        logic [DW-1:0] v;
    } opnd_t;

    typedef struct packed {
        logic    busy;
        alu_op_e op;
        opnd_t   j;
        opnd_t   k;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_ENT-1:0] slot;
    } state_t;

    state_t s_q, s_d;

    logic [NUM_ENT-1:0] busy_vec, req_vec, pick_oh, alloc_oh, gnt_oh;
    logic [IW-1:0]      pick_idx, gnt_idx;
    logic               alloc_fire;
    logic [DW-1:0]      iss_a, iss_b;
    alu_op_e            iss_op;

    function automatic opnd_t snoop(
        input opnd_t         o,
        input logic          cv,
        input logic [TW-1:0] ct,
        input logic [DW-1:0] cd,
        input logic          rv,
        input logic [TW-1:0] rt,
        input logic [DW-1:0] rd,
        input logic          wv,
        input logic [TW-1:0] wt
    );
        opnd_t n;
        n = o;
        if (!o.rdy) begin
            if (cv && ct == o.q) begin
                n.v   = cd;
                n.rdy = 1'b1;
            end else if (rv && rt == o.q) begin
                n.v   = rd;
                n.rdy = 1'b1;
            end else if (wv && wt == o.q) begin
                n.rdy  = 1'b1;
                n.pend = 1'b1;
            end
        end else if (o.pend) begin
            n.pend = 1'b0;
            if (rv && rt == o.q) n.v = rd;
        end
        return n;
    endfunction

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            busy_vec[i] = s_q.slot[i].busy;
            req_vec[i]  = s_q.slot[i].busy && s_q.slot[i].j.rdy && s_q.slot[i].k.rdy;
        end
    end

    rs_free_pick #(.NUM_ENT(NUM_ENT)) u_pick (
        .busy     (busy_vec),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx),
        .all_busy (disp_full)
    );

    assign alloc_fire = disp_valid && !disp_full;
    assign alloc_oh   = pick_oh & {NUM_ENT{alloc_fire}};
    assign disp_tag   = TW'(BASE_TAG) + TW'(pick_idx);

    rs_age_sel #(.NUM_ENT(NUM_ENT)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (alloc_oh),
        .busy     (busy_vec),
        .req      (req_vec),
        .gnt_oh   (gnt_oh)
    );

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (gnt_oh[i]) gnt_idx = IW'(i);
        end
    end

    assign issue_valid = |gnt_oh;
    assign issue_tag   = TW'(BASE_TAG) + TW'(gnt_idx);
    assign iss_op      = s_q.slot[gnt_idx].op;
    assign iss_a       = s_q.slot[gnt_idx].j.pend ? res_data : s_q.slot[gnt_idx].j.v;
    assign iss_b       = s_q.slot[gnt_idx].k.pend ? res_data : s_q.slot[gnt_idx].k.v;

    rs_fu_pipe #(
        .DW         (DW),
        .TW         (TW),
        .LAT        (LAT),
        .EARLY_WAKE (EARLY_WAKE)
    ) u_fu (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (issue_valid),
        .iss_tag    (issue_tag),
        .iss_op     (iss_op),
        .opa        (iss_a),
        .opb        (iss_b),
        .res_valid  (res_valid),
        .res_tag    (res_tag),
        .res_data   (res_data),
        .wake_valid (wake_valid),
        .wake_tag   (wake_tag)
    );

    always_comb begin
        opnd_t nj, nk;
        s_d = s_q;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (s_q.slot[i].busy) begin
                s_d.slot[i].j = snoop(s_q.slot[i].j, cdb_valid, cdb_tag, cdb_data,
                                      res_valid, res_tag, res_data, wake_valid, wake_tag);
                s_d.slot[i].k = snoop(s_q.slot[i].k, cdb_valid, cdb_tag, cdb_data,
                                      res_valid, res_tag, res_data, wake_valid, wake_tag);
            end
            if (gnt_oh[i]) s_d.slot[i].busy = 1'b0;
        end
        nj.rdy  = disp_rj;
        nj.pend = 1'b0;
        nj.q    = disp_qj;
        nj.v    = disp_vj;
        nk.rdy  = disp_rk;
        nk.pend = 1'b0;
        nk.q    = disp_qk;
        nk.v    = disp_vk;
        if (alloc_fire) begin
            s_d.slot[pick_idx].busy = 1'b1;
            s_d.slot[pick_idx].op   = alu_op_e'(disp_op);
            s_d.slot[pick_idx].j    = snoop(nj, cdb_valid, cdb_tag, cdb_data,
                                            res_valid, res_tag, res_data, wake_valid, wake_tag);
            s_d.slot[pick_idx].k    = snoop(nk, cdb_valid, cdb_tag, cdb_data,
                                            res_valid, res_tag, res_data, wake_valid, wake_tag);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
    parameter int NUM_ENT    = 4,
    parameter int LAT        = 2,
    parameter bit EARLY_WAKE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               disp_full,
    input logic               issue_valid,
    input logic               res_valid,
    input logic               wake_valid,
    input logic [NUM_ENT-1:0] gnt_oh,
    input logic [NUM_ENT-1:0] req_vec
);

    logic [LAT-1:0] lat_sr;

    always_ff @(posedge clk) begin
        if (!rst_n) lat_sr <= '0;
        else        lat_sr <= (lat_sr << 1) | LAT'(issue_valid);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh)); // R4

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_oh & ~req_vec) == '0); // R4

    AST_NO_IDLE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) |-> issue_valid); // R6

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_full && !issue_valid) |=> disp_full); // R2

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == lat_sr[LAT-1]); // R7

    if (EARLY_WAKE && LAT >= 2) begin : g_lead
        AST_WAKE_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            wake_valid |=> res_valid); // R9
    end

endmodule

bind rs_bank rs_bank_chk #(
    .NUM_ENT    (NUM_ENT),
    .LAT        (LAT),
    .EARLY_WAKE (EARLY_WAKE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_full   (disp_full),
    .issue_valid (issue_valid),
    .res_valid   (res_valid),
    .wake_valid  (wake_valid),
    .gnt_oh      (gnt_oh),
    .req_vec     (req_vec)
);

// File: tb/rs_bank_test.sv
module rs_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int TW = 5;
    localparam int NV = 6;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 16'h1234, 16'h0111},
        {2'd1, 16'h0005, 16'h0007},
        {2'd2, 16'h0100, 16'h0100},
        {2'd2, 16'h0123, 16'h0010},
        {2'd3, 16'hFFFF, 16'h0F0F},
        {2'd0, 16'hFFFF, 16'h0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_rj = 1'b0, disp_rk = 1'b0, cdb_valid = 1'b0;
    logic [1:0]    disp_op = '0;
    logic [DW-1:0] disp_vj = '0, disp_vk = '0, cdb_data = '0;
    logic [TW-1:0] disp_qj = '0, disp_qk = '0, cdb_tag = '0;

    logic full_e, full_l, iv_e, iv_l, rv_e, rv_l, wv_e, wv_l;
    logic [TW-1:0] dt_e, dt_l, it_e, it_l, rt_e, rt_l, wt_e, wt_l;
    logic [DW-1:0] rd_e, rd_l;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_bank #(.EARLY_WAKE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_vj(disp_vj), .disp_rj(disp_rj), .disp_qj(disp_qj),
        .disp_vk(disp_vk), .disp_rk(disp_rk), .disp_qk(disp_qk),
        .disp_full(full_e), .disp_tag(dt_e),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .issue_valid(iv_e), .issue_tag(it_e),
        .res_valid(rv_e), .res_tag(rt_e), .res_data(rd_e),
        .wake_valid(wv_e), .wake_tag(wt_e)
    );

    rs_bank #(.EARLY_WAKE(1'b0)) uut_late (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_vj(disp_vj), .disp_rj(disp_rj), .disp_qj(disp_qj),
        .disp_vk(disp_vk), .disp_rk(disp_rk), .disp_qk(disp_qk),
        .disp_full(full_l), .disp_tag(dt_l),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .issue_valid(iv_l), .issue_tag(it_l),
        .res_valid(rv_l), .res_tag(rt_l), .res_data(rd_l),
        .wake_valid(wv_l), .wake_tag(wt_l)
    );

    function automatic logic [DW-1:0] model(input logic [1:0] op, input logic [DW-1:0] a, b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a * b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        disp_valid = 1'b0;
        cdb_valid  = 1'b0;
    endtask

    task automatic disp(input logic [1:0] op, input logic [DW-1:0] vj, input logic rj,
                        input logic [TW-1:0] qj, input logic [DW-1:0] vk, input logic rk,
                        input logic [TW-1:0] qk);
        disp_valid = 1'b1;
        disp_op = op;
        disp_vj = vj; disp_rj = rj; disp_qj = qj;
        disp_vk = vk; disp_rk = rk; disp_qk = qk;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
        cdb_valid = 1'b1;
        cdb_tag   = t;
        cdb_data  = d;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        nfail++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: empty after reset
        chk("R1 full", {full_e, full_l}, 2'b00);
        chk("R1 issue", {iv_e, iv_l}, 2'b00);
        chk("R1 res", {rv_e, rv_l}, 2'b00);
        chk("R1 wake", {wv_e, wv_l}, 2'b00);
        chk("R1 disp_tag", dt_e, 8);

        // R7: table of independent operations, one at a time
        for (int n = 0; n < NV; n++) begin
            logic [1:0] op;
            logic [DW-1:0] a, b;
            {op, a, b} = VEC[n];
            chk("R2 disp_tag", dt_e, 8);
            disp(op, a, 1'b1, '0, b, 1'b1, '0);
            tick();
            idle();
            chk("R4 issue", {iv_e, iv_l}, 2'b11);
            chk("R4 issue_tag", it_e, 8);
            tick();
            tick();
            chk("R7 res_valid", {rv_e, rv_l}, 2'b11);
            chk("R7 res_tag", rt_l, 8);
            chk("R7 res_data early", rd_e, model(op, a, b));
            chk("R7 res_data late", rd_l, model(op, a, b));
            tick();
        end
        repeat (3) tick();

        // R8 / R9: dependent pair through own result
        disp(2'd0, 16'd3, 1'b1, '0, 16'd4, 1'b1, '0);
        tick();
        chk("R4 producer pick", {iv_e, iv_l}, 2'b11);
        disp(2'd2, '0, 1'b0, 5'd8, 16'd5, 1'b1, '0);
        chk("R2 lowest free", dt_e, 9);
        tick();
        idle();
        chk("R9 wake early", {wv_e, wt_e}, {1'b1, 5'd8});
        chk("R8 wake late idle", wv_l, 1'b0);
        chk("R4 dependant waits", {iv_e, iv_l}, 2'b00);
        tick();
        chk("R9 back-to-back pick", {iv_e, it_e}, {1'b1, 5'd9});
        chk("R8 late not yet", iv_l, 1'b0);
        chk("R7 producer data", {rd_e, rd_l}, {16'd7, 16'd7});
        chk("R8 wake mirrors res", {wv_l, wt_l}, {1'b1, 5'd8});
        tick();
        chk("R8 late pick", {iv_l, it_l}, {1'b1, 5'd9});
        chk("R9 early done", iv_e, 1'b0);
        tick();
        chk("R9 bypassed result", {rv_e, rt_e, rd_e}, {1'b1, 5'd9, 16'd35});
        chk("R8 late result pending", rv_l, 1'b0);
        tick();
        chk("R8 late result", {rv_l, rt_l, rd_l}, {1'b1, 5'd9, 16'd35});
        repeat (3) tick();

        // R5 / R6: age order beats index, loser retries
        disp(2'd0, '0, 1'b0, 5'd20, 16'd1, 1'b1, '0);   // slot 0 waits on 20
        tick();
        disp(2'd0, 16'd1, 1'b1, '0, 16'd1, 1'b1, '0);   // slot 1 ready
        tick();
        chk("R4 ready slot picked", {iv_e, it_e}, {1'b1, 5'd9});
        disp(2'd1, '0, 1'b0, 5'd21, 16'd2, 1'b1, '0);   // slot 2 waits on 21
        tick();
        chk("R6 freed slot reused", dt_e, 9);
        disp(2'd3, '0, 1'b0, 5'd21, 16'h00FF, 1'b1, '0); // slot 1 waits on 21
        tick();
        idle();
        bcast(5'd21, 16'h0100);
        chk("R4 none ready", {iv_e, iv_l}, 2'b00);
        chk("R7 ready slot result", {rv_e, rt_e, rd_e}, {1'b1, 5'd9, 16'd2});
        tick();
        idle();
        chk("R5 oldest wins early", it_e, 10);
        chk("R5 oldest wins late", it_l, 10);
        tick();
        chk("R6 loser retried", {iv_e, it_e, iv_l, it_l}, {1'b1, 5'd9, 1'b1, 5'd9});
        tick();
        chk("R3 waiting slot idle", {iv_e, iv_l}, 2'b00);
        chk("R7 sub result", {rt_e, rd_e}, {5'd10, 16'h00FE});
        bcast(5'd20, 16'd5);
        tick();
        idle();
        chk("R7 xor result", {rt_l, rd_l}, {5'd9, 16'h01FF});
        chk("R3 bus capture", {iv_e, it_e}, {1'b1, 5'd8});
        tick();
        tick();
        chk("R3 captured value", {rd_e, rd_l}, {16'd6, 16'd6});
        repeat (3) tick();

        // R3: capture in the dispatch cycle
        disp(2'd0, '0, 1'b0, 5'd22, 16'd10, 1'b1, '0);
        bcast(5'd22, 16'h0020);
        tick();
        idle();
        chk("R3 same-cycle capture", {iv_e, iv_l}, 2'b11);
        tick();
        tick();
        chk("R3 same-cycle data", {rd_e, rd_l}, {16'h002A, 16'h002A});
        repeat (3) tick();

        // R2: fill, dispatch while full is dropped
        for (int i = 0; i < 4; i++) begin
            disp(2'd0, '0, 1'b0, 5'd23, 16'(i + 1), 1'b1, '0);
            tick();
        end
        idle();
        chk("R2 full", {full_e, full_l}, 2'b11);
        disp(2'd0, 16'h0077, 1'b1, '0, 16'd1, 1'b1, '0);
        tick();
        idle();
        chk("R2 dropped dispatch", {iv_e, iv_l, full_e}, 3'b001);
        bcast(5'd23, 16'h0100);
        tick();
        idle();
        for (int i = 0; i < 4; i++) begin
            chk("R5 allocation order", {iv_e, it_e, iv_l, it_l},
                {1'b1, 5'(8 + i), 1'b1, 5'(8 + i)});
            if (i == 2) chk("R7 first of burst", rd_e, 16'h0101);
            tick();
        end
        chk("R2 nothing extra", {iv_e, iv_l, full_e}, 3'b000);
        repeat (3) tick();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule